// File: doc/BRIEF.md
# Serial Port-Expander Register Core

This block holds the registers and the line logic of an eight-line port expander that sits behind a two-wire serial target. The serial engine in front of it has already handled bit timing and address matching. It hands this core byte-level events: a write-transaction start, a read-transaction start, a stop, a received byte, and a request for a byte to send back. For each received byte the core returns an accept or reject flag. For each read request it returns one data byte.

The first byte after a write start is taken as a register pointer. Later bytes in the same write go to the register that the pointer selects. There are five registers: input level, output latch, polarity inversion, direction (1 = input) and timeout. Input-configured lines follow the sampled pins every clock. Output-configured lines are driven from the output latch. A write can carry at most two bytes. A read returns the register at the current pointer and leaves the pointer where it is.

Top module: `pexp_core`

## Requirements
- R1: After reset, direction reads 0xFF, polarity reads 0xF0, timeout reads 0x01, the pointer is 0 and every output line is driven low.
- R2: The first byte after a write start is accepted (ack_o = 1). It loads the pointer and changes no register.
- R3: Pointer 0 reads the line levels XOR the polarity register, where input-configured levels follow pin_in_i. A data byte written to pointer 0 is accepted and changes nothing.
- R4: Pointer 1 reads the output latch masked to output-configured lines. A write there changes only lines whose direction bit is 0. pin_out_o shows the new value in the same cycle that ack_o reports the byte. Input-configured lines drive 0.
- R5: Pointers 2 (polarity), 3 (direction, 1 = input) and 4 (timeout) read back the full byte last written to them.
- R6: A direction write clears the level of every line whose direction bit changes, before the new direction is stored.
- R7: A read while the pointer is above 4 (including 0xFF) returns 0xFF.
- R8: Any received byte after the second in one transaction is rejected (ack_o = 0) and writes nothing. Every write start, read start or stop clears the byte count.
- R9: A data byte sent to a pointer above 4 is rejected and changes no register.
- R10: pin_in_i has no effect on output-configured lines. pin_out_o changes only after a received byte.
- R11: A read returns the register at the current pointer and does not move it, so repeated reads return the same register.
- R12: ack_vld_o pulses one cycle after each received byte. rd_vld_o, carrying rd_data_o, pulses one cycle after each read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start_i | input | 1 | Write-transaction start strobe |
| rd_start_i | input | 1 | Read-transaction start strobe |
| stop_i | input | 1 | Transaction stop strobe |
| byte_vld_i | input | 1 | Received-byte strobe |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request for a byte to transmit |
| rd_data_o | output | 8 | Byte to transmit |
| rd_vld_o | output | 1 | rd_data_o valid |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_o | output | 1 | 1 = byte accepted, 0 = rejected |
| pin_in_i | input | 8 | Sampled line levels |
| pin_out_o | output | 8 | Driven line levels |

## Verification
Some properties are checked on every cycle: the one-cycle response timing of accept flags and read data, rejection of any byte past the transaction length limit or aimed at an unknown pointer, 0xFF from unknown pointers, and a pointer that stays put across reads. Another every-cycle check is that output lines hold steady unless a byte arrives, which shows that pin activity cannot reach them. Other behaviours need the scoreboard scenarios, because they depend on the history of register contents. These are the reset values, the polarity XOR on the input register, masking of output writes by direction, and clearing of levels when direction flips. The scenarios also show that the pointer byte writes nothing and that a restart clears the byte count without re-arming the pointer.

// File: rtl/pexp_pkg.sv
// Shared types for the port-expander register core.
// Assumes the register select is decoded once, in the transaction tracker.
package pexp_pkg;
    // Decoded register selected by the command pointer
    typedef enum logic [2:0] {
        SEL_INPUT   = 3'd0,
        SEL_OUTPUT  = 3'd1,
        SEL_POLAR   = 3'd2,
        SEL_CONFIG  = 3'd3,
        SEL_TIMEOUT = 3'd4,
        SEL_NONE    = 3'd7
    } sel_e;

    // Highest pointer value that selects a register
    localparam int LAST_CMD = 4;
endpackage

// File: rtl/pexp_xact.sv
// Transaction tracker: holds the command pointer and the byte count, and
// turns received bytes into pointer loads or register write strobes.
// Assumes at most one of start/stop/byte per cycle; events win over a byte.
module pexp_xact
    import pexp_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int MAX_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start_i,
    input  logic             rd_start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic [LINES-1:0] byte_i,
    output logic [LINES-1:0] cmd_ptr_o,
    output logic             ptr_pending_o,
    output sel_e             sel_o,
    output logic             wr_en_o,
    output logic             ack_vld_o,
    output logic             ack_o
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_BYTES);
    localparam logic [LINES-1:0] C_IN  = LINES'(0);
    localparam logic [LINES-1:0] C_OUT = LINES'(1);
    localparam logic [LINES-1:0] C_POL = LINES'(2);
    localparam logic [LINES-1:0] C_CFG = LINES'(3);
    localparam logic [LINES-1:0] C_TMO = LINES'(4);

    logic [CNT_W-1:0] cnt_q;
    logic             pending_q;
    logic [LINES-1:0] cmd_q;
    logic             any_evt;
    logic             take;
    logic             over;
    logic             accept;

    // Classify this cycle's byte: taken, over the length limit, accepted
    always_comb begin
        any_evt = wr_start_i | rd_start_i | stop_i;
        take    = byte_vld_i & ~any_evt;
        over    = (cnt_q >= CNT_LIM);
        wr_en_o = take & ~over & ~pending_q;
        accept  = take & ~over & (pending_q | (sel_o != SEL_NONE));
    end

    // Decode the pointer into a register select
    always_comb begin
        case (cmd_q)
            C_IN:    sel_o = SEL_INPUT;
            C_OUT:   sel_o = SEL_OUTPUT;
            C_POL:   sel_o = SEL_POLAR;
            C_CFG:   sel_o = SEL_CONFIG;
            C_TMO:   sel_o = SEL_TIMEOUT;
            default: sel_o = SEL_NONE;
        endcase
    end

    // Pointer, pending flag, byte count and acknowledge registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pending_q <= 1'b0;
            cmd_q     <= '0;
            ack_vld_o <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            ack_vld_o <= take;
            ack_o     <= accept;
            if (any_evt) begin
                cnt_q <= '0;
                if (wr_start_i) pending_q <= 1'b1;
            end else if (take && !over) begin
                cnt_q <= cnt_q + 1'b1;
                if (pending_q) begin
                    cmd_q     <= byte_i;
                    pending_q <= 1'b0;
                end
            end
        end
    end

    assign cmd_ptr_o     = cmd_q;
    assign ptr_pending_o = pending_q;
endmodule

// File: rtl/pexp_regs.sv
// Register file: line levels, direction, polarity and timeout.
// Input-configured levels track the pins every clock; writes are pre-decoded.
module pexp_regs
    import pexp_pkg::*;
#(
    parameter int               LINES   = 8,
    parameter logic [LINES-1:0] DIR_RST = '1,
    parameter logic [LINES-1:0] POL_RST = LINES'(8'hF0),
    parameter logic [LINES-1:0] TMO_RST = LINES'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  sel_e             wr_sel_i,
    input  logic [LINES-1:0] wr_data_i,
    input  logic [LINES-1:0] pin_in_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] dir_o,
    output logic [LINES-1:0] pol_o,
    output logic [LINES-1:0] tmo_o
);
    logic [LINES-1:0] level_q;
    logic [LINES-1:0] level_nxt;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] tmo_q;
    logic             wr_out;
    logic             wr_cfg;

    assign wr_out = wr_en_i && (wr_sel_i == SEL_OUTPUT);
    assign wr_cfg = wr_en_i && (wr_sel_i == SEL_CONFIG);

    // Whole-byte registers: direction, polarity, timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_RST;
            pol_q <= POL_RST;
            tmo_q <= TMO_RST;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_CONFIG:  dir_q <= wr_data_i;
                SEL_POLAR:   pol_q <= wr_data_i;
                SEL_TIMEOUT: tmo_q <= wr_data_i;
                default:     ;
            endcase
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Next level of one line: pin sample, latch write, direction clear
        always_comb begin
            level_nxt[g] = dir_q[g] ? pin_in_i[g] : level_q[g];
            if (wr_out && !dir_q[g]) level_nxt[g] = wr_data_i[g];
            if (wr_cfg && (dir_q[g] ^ wr_data_i[g])) level_nxt[g] = 1'b0;
        end

        // Level flop of one line; reset keeps it only where it was an input
        always_ff @(posedge clk) begin
            if (!rst_n) level_q[g] <= level_q[g] & dir_q[g];
            else        level_q[g] <= level_nxt[g];
        end
    end

    assign level_o = level_q;
    assign dir_o   = dir_q;
    assign pol_o   = pol_q;
    assign tmo_o   = tmo_q;
endmodule

// File: rtl/pexp_rdmux.sv
// Read path: selects the register at the pointer and registers it on a
// read request. Assumes the select is stable in the request cycle.
module pexp_rdmux
    import pexp_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req_i,
    input  sel_e             sel_i,
    input  logic [LINES-1:0] level_i,
    input  logic [LINES-1:0] dir_i,
    input  logic [LINES-1:0] pol_i,
    input  logic [LINES-1:0] tmo_i,
    output logic [LINES-1:0] rd_data_o,
    output logic             rd_vld_o
);
    logic [LINES-1:0] view;

    // Register view for the current select
    always_comb begin
        case (sel_i)
            SEL_INPUT:   view = level_i ^ pol_i;
            SEL_OUTPUT:  view = level_i & ~dir_i;
            SEL_POLAR:   view = pol_i;
            SEL_CONFIG:  view = dir_i;
            SEL_TIMEOUT: view = tmo_i;
            default:     view = '1;
        endcase
    end

    // Capture the view on a read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            rd_vld_o  <= 1'b0;
        end else begin
            rd_vld_o <= rd_req_i;
            if (rd_req_i) rd_data_o <= view;
        end
    end
endmodule

// File: rtl/pexp_core.sv
// Port-expander register core: byte-level events in, accept flags and read
// bytes out, plus line drive. Assumes one register per serial byte, so
// LINES also sets the byte width.
module pexp_core
    import pexp_pkg::*;
#(
    parameter int               LINES     = 8,
    parameter int               MAX_BYTES = 2,
    parameter logic [LINES-1:0] DIR_RST   = '1,
    parameter logic [LINES-1:0] POL_RST   = LINES'(8'hF0),
    parameter logic [LINES-1:0] TMO_RST   = LINES'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start_i,
    input  logic             rd_start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic [LINES-1:0] byte_i,
    input  logic             rd_req_i,
    output logic [LINES-1:0] rd_data_o,
    output logic             rd_vld_o,
    output logic             ack_vld_o,
    output logic             ack_o,
    input  logic [LINES-1:0] pin_in_i,
    output logic [LINES-1:0] pin_out_o
);
    logic [LINES-1:0] cmd_ptr;
    logic             ptr_pending;
    sel_e             cmd_sel;
    logic             wr_en;
    logic [LINES-1:0] level;
    logic [LINES-1:0] dir;
    logic [LINES-1:0] pol;
    logic [LINES-1:0] tmo;

    pexp_xact #(.LINES(LINES), .MAX_BYTES(MAX_BYTES)) u_xact (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_start_i    (wr_start_i),
        .rd_start_i    (rd_start_i),
        .stop_i        (stop_i),
        .byte_vld_i    (byte_vld_i),
        .byte_i        (byte_i),
        .cmd_ptr_o     (cmd_ptr),
        .ptr_pending_o (ptr_pending),
        .sel_o         (cmd_sel),
        .wr_en_o       (wr_en),
        .ack_vld_o     (ack_vld_o),
        .ack_o         (ack_o)
    );

    pexp_regs #(.LINES(LINES), .DIR_RST(DIR_RST), .POL_RST(POL_RST),
                .TMO_RST(TMO_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (cmd_sel),
        .wr_data_i (byte_i),
        .pin_in_i  (pin_in_i),
        .level_o   (level),
        .dir_o     (dir),
        .pol_o     (pol),
        .tmo_o     (tmo)
    );

    pexp_rdmux #(.LINES(LINES)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req_i  (rd_req_i),
        .sel_i     (cmd_sel),
        .level_i   (level),
        .dir_i     (dir),
        .pol_i     (pol),
        .tmo_i     (tmo),
        .rd_data_o (rd_data_o),
        .rd_vld_o  (rd_vld_o)
    );

    // Line drive: output-configured lines follow the latch, inputs drive 0
    for (genvar g = 0; g < LINES; g++) begin : g_drive
        assign pin_out_o[g] = ~dir[g] & level[g];
    end
endmodule

// File: rtl/pexp_core_chk.sv
// Protocol checker for pexp_core, attached by bind. Keeps its own count of
// bytes since the last start/stop to judge the length limit.
module pexp_core_chk #(
    parameter int LINES     = 8,
    parameter int MAX_BYTES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_start_i,
    input logic             rd_start_i,
    input logic             stop_i,
    input logic             byte_vld_i,
    input logic             rd_req_i,
    input logic [LINES-1:0] rd_data_o,
    input logic             rd_vld_o,
    input logic             ack_vld_o,
    input logic             ack_o,
    input logic [LINES-1:0] pin_out_o,
    input logic [LINES-1:0] cmd_ptr,
    input logic             ptr_pending
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(MAX_BYTES);
    localparam logic [LINES-1:0] LAST = LINES'(pexp_pkg::LAST_CMD);

    logic             evt;
    logic             byte_in;
    logic [CNT_W-1:0] seen_q;

    assign evt     = wr_start_i | rd_start_i | stop_i;
    assign byte_in = byte_vld_i & ~evt;

    // Independent count of bytes in the current transaction
    always_ff @(posedge clk) begin
        if (!rst_n)                       seen_q <= '0;
        else if (evt)                     seen_q <= '0;
        else if (byte_in && seen_q < LIM) seen_q <= seen_q + 1'b1;
    end

    assert_ack_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_in |=> ack_vld_o);
    assert_no_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_in |=> !ack_vld_o);
    assert_rd_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_vld_o);
    assert_len_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_in && seen_q >= LIM) |=> (ack_vld_o && !ack_o));
    assert_unknown_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_in && !ptr_pending && cmd_ptr > LAST) |=> !ack_o);
    assert_high_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && cmd_ptr > LAST) |=> (rd_data_o == '1));
    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !byte_vld_i) |=> $stable(cmd_ptr));
    assert_pins_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |=> $stable(pin_out_o));
endmodule

bind pexp_core pexp_core_chk #(.LINES(LINES), .MAX_BYTES(MAX_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_start_i  (wr_start_i),
    .rd_start_i  (rd_start_i),
    .stop_i      (stop_i),
    .byte_vld_i  (byte_vld_i),
    .rd_req_i    (rd_req_i),
    .rd_data_o   (rd_data_o),
    .rd_vld_o    (rd_vld_o),
    .ack_vld_o   (ack_vld_o),
    .ack_o       (ack_o),
    .pin_out_o   (pin_out_o),
    .cmd_ptr     (cmd_ptr),
    .ptr_pending (ptr_pending)
);

// File: tb/pexp_core_tb.sv
// Scoreboard bench: driver tasks queue the expected accept flags and read
// bytes; a monitor pops and compares them as the core responds.
`timescale 1ns/1ps
module pexp_core_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_start_i, rd_start_i, stop_i, byte_vld_i, rd_req_i;
    logic [7:0] byte_i, pin_in_i;
    logic [7:0] rd_data_o, pin_out_o;
    logic       rd_vld_o, ack_vld_o, ack_o;

    always #4 clk = ~clk;

    pexp_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start_i), .rd_start_i(rd_start_i),
        .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i),
        .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
        .pin_in_i(pin_in_i), .pin_out_o(pin_out_o)
    );

    typedef struct {
        bit         is_rd;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare on every response from the core
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n === 1'b1 && (ack_vld_o === 1'b1 || rd_vld_o === 1'b1)) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R12 unexpected response: got ack_vld=%b rd_vld=%b expected none",
                         ack_vld_o, rd_vld_o);
            end else begin
                e = sb.pop_front();
                if (e.is_rd != rd_vld_o) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R12 %s kind: got rd_vld=%b expected %b", e.tag, rd_vld_o, e.is_rd);
                end else if (e.is_rd) check(e.tag, rd_data_o, e.val);
                else                  check(e.tag, {7'b0, ack_o}, e.val);
            end
        end
    end

    task automatic push(input bit is_rd, input logic [7:0] v, input string tag);
        exp_t e;
        e.is_rd = is_rd; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wstart();
        @(negedge clk); wr_start_i = 1'b1; @(negedge clk); wr_start_i = 1'b0;
    endtask
    task automatic rstart();
        @(negedge clk); rd_start_i = 1'b1; @(negedge clk); rd_start_i = 1'b0;
    endtask
    task automatic stop();
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask
    task automatic send(input logic [7:0] d, input bit exp_ack, input string tag);
        @(negedge clk);
        push(1'b0, {7'b0, exp_ack}, tag);
        byte_i = d; byte_vld_i = 1'b1;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask
    task automatic rd(input logic [7:0] exp, input string tag);
        @(negedge clk);
        push(1'b1, exp, tag);
        rd_req_i = 1'b1;
        @(negedge clk); rd_req_i = 1'b0;
    endtask
    task automatic wr_reg(input logic [7:0] c, input logic [7:0] d, input string tag);
        wstart(); send(c, 1'b1, tag); send(d, 1'b1, tag); stop();
    endtask
    task automatic rd_reg(input logic [7:0] c, input logic [7:0] exp, input string tag);
        wstart(); send(c, 1'b1, tag); rstart(); rd(exp, tag); stop();
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog: got no completion expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_start_i = 0; rd_start_i = 0; stop_i = 0;
        byte_vld_i = 0; rd_req_i = 0; byte_i = 8'h00; pin_in_i = 8'hA5;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check("R1 pins after reset", pin_out_o, 8'h00);
        rstart(); rd(8'h55, "R1 pointer 0 after reset, R3 xor F0"); stop();
        rd_reg(8'h03, 8'hFF, "R1 direction reset");
        rd_reg(8'h02, 8'hF0, "R1 polarity reset");
        rd_reg(8'h04, 8'h01, "R1 timeout reset");

        // R5: whole-byte registers
        wr_reg(8'h02, 8'h00, "R5 polarity write");
        rd_reg(8'h02, 8'h00, "R5 polarity readback");
        wr_reg(8'h04, 8'h3C, "R5 timeout write");
        rd_reg(8'h04, 8'h3C, "R5 timeout readback");

        // R3 / R11: input register follows pins, repeated reads
        rd_reg(8'h00, 8'hA5, "R3 input with zero polarity");
        pin_in_i = 8'h3C; idle(2);
        rstart(); rd(8'h3C, "R3 input follows pins"); rd(8'h3C, "R11 repeat read"); stop();
        wr_reg(8'h00, 8'hFF, "R3 write to input accepted");
        rd_reg(8'h00, 8'h3C, "R3 write to input ignored");

        // R6: low nibble input, high nibble output; flipped lines cleared
        wr_reg(8'h03, 8'h0F, "R6 direction write");
        check("R6 cleared outputs", pin_out_o, 8'h00);
        rd_reg(8'h01, 8'h00, "R6 cleared latch");

        // R4: output write masked by direction, pin changes with ack
        wstart(); send(8'h01, 1'b1, "R4 pointer"); send(8'hA5, 1'b1, "R4 latch write");
        check("R4 pin same cycle as ack", pin_out_o, 8'hA0);
        stop();
        rd_reg(8'h01, 8'hA0, "R4 latch masked read");
        rd_reg(8'h00, 8'hAC, "R4 input lines untouched");

        // R10: pins do not reach output lines
        pin_in_i = 8'hFF; idle(2);
        check("R10 outputs hold", pin_out_o, 8'hA0);
        rd_reg(8'h00, 8'hAF, "R10 only input lines follow pins");

        // R8: length limit and count clearing
        wstart(); send(8'h02, 1'b1, "R8 byte 1"); send(8'h11, 1'b1, "R8 byte 2");
        send(8'h22, 1'b0, "R8 byte 3 rejected"); send(8'h33, 1'b0, "R8 byte 4 rejected"); stop();
        rd_reg(8'h02, 8'h11, "R8 rejected bytes not written");
        wstart(); send(8'h02, 1'b1, "R8 pointer"); send(8'h55, 1'b1, "R8 data");
        rstart(); send(8'h66, 1'b1, "R8 count cleared by restart"); stop();
        rd_reg(8'h02, 8'h66, "R8 byte after restart written");
        wr_reg(8'h02, 8'h00, "R8 polarity restore");

        // R9 / R7: unknown pointer
        wstart(); send(8'h07, 1'b1, "R2 pointer 7"); send(8'h12, 1'b0, "R9 unknown write rejected"); stop();
        rd_reg(8'h07, 8'hFF, "R7 read pointer 7");
        rd_reg(8'hFF, 8'hFF, "R7 read pointer FF");
        rd_reg(8'h04, 8'h3C, "R9 timeout unchanged");
        rd_reg(8'h02, 8'h00, "R9 polarity unchanged");

        // R6: input lines turned to outputs come up cleared
        wr_reg(8'h03, 8'h00, "R6 all outputs");
        check("R6 former inputs cleared", pin_out_o, 8'hA0);
        rd_reg(8'h03, 8'h00, "R5 direction readback");
        rd_reg(8'h01, 8'hA0, "R6 latch after flip");

        // R2: pointer byte writes nothing
        wr_reg(8'h02, 8'h5A, "R2 polarity setup");
        wstart(); send(8'h04, 1'b1, "R2 pointer only"); stop();
        rstart(); rd(8'h3C, "R2 pointer loaded"); stop();
        rd_reg(8'h02, 8'h5A, "R2 no register written");

        idle(3);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R12 pending responses: got %0d expected 0", sb.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule